// File: doc/BRIEF.md
# Video Memory Access Port

This block is the processor's only path into a separate 14-bit video address space. The processor sets a location by writing the address register twice, high byte first and then low byte. It then moves bytes through the data register. After every data access the location advances by 1 or by 32, so software can walk along a row or down a column of a tile map.

Reads are buffered. A data read returns whatever the internal buffer held before the read, then refills the buffer from the location just addressed. The first read after setting an address therefore returns stale data. Every address is folded onto physical storage before it reaches the memory port:
- The four logical name tables collapse onto two physical 1 KB tables, according to a static mirroring input.
- The two palette backdrop locations share one cell.
- The unused window gets no memory access at all.
- Pattern storage can be flagged read-only.

The processor is expected to leave at least three clock cycles between accesses to the data register.

Top module: `vram_port`

## Requirements
- R1: After reset the current address is 0x0000, the address-write sequence expects the high byte, the read buffer and `rdData` are 0, and `memReq`/`memWe` are low.
- R2: Register select 0 is the address register. The first write holds bits 5:0 of `wrData` as address bits 13:8 and drops bits 7:6. The second write supplies bits 7:0, and the whole new address takes effect on that second write.
- R3: A read with register select 2 returns the address-write sequence to "expect high byte".
- R4: A write with register select 1 drives `memReq`/`memWe` high in the next cycle, with `memWdata` and the folded location of the current address. The address then advances by 32 when `incBy32` is 1 and by 1 otherwise.
- R5: The address is 14 bits wide and wraps modulo 0x4000 when it advances.
- R6: A read with register select 1 presents the buffer on `rdData` in that same cycle and issues a memory read of the current address in the next cycle. The returned byte is visible on `rdData` from the third cycle after the read. The address advances by the same rule as for writes.
- R7: Addresses 0x2000–0x2FFF go to area 1 (`memArea`=1) with index {table, addr[9:0]}. The table is addr[10] when `mirrorVert`=1 (tables 2 and 3 alias 0 and 1) and addr[11] when `mirrorVert`=0 (tables 1 and 3 alias 0 and 2).
- R8: Addresses 0x3F00–0x3FFF go to area 2 with index addr[4:0], except that index 0x10 becomes 0x00, so 0x3F10 and 0x3F00 are one cell.
- R9: Addresses 0x0000–0x1FFF go to area 0 with index addr[12:0]. While `patternRo`=1, data writes there issue no memory write, but reads still work.
- R10: Addresses 0x3000–0x3EFF issue no memory access. Writes there are dropped, and reads load 0 into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Processor register write strobe |
| regRead | input | 1 | Processor register read strobe |
| regSel | input | 2 | 0 address, 1 data, 2 status, 3 unused |
| wrData | input | 8 | Processor write data |
| incBy32 | input | 1 | Step select: 1 = 32, 0 = 1 |
| mirrorVert | input | 1 | Static name-table mirroring select |
| patternRo | input | 1 | Pattern area is read-only |
| rdData | output | 8 | Read buffer contents |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write enable |
| memArea | output | 2 | 0 pattern, 1 name table, 2 palette |
| memIndex | output | 13 | Folded index within the area |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid the cycle after a read request |

## Verification
The bench keeps a behavioural model of the logical address space and compares the buffered read data against it every cycle. It writes through one alias and reads through another, so a design that folded the name tables by the wrong address bit, or kept 0x3F10 apart from 0x3F00, would return a stale or zero byte. It interrupts an address sequence with a status read: a design that did not reset the high/low sequence would take the next high byte as a low byte and write elsewhere. It also steps across 0x3FFF, which exposes an address that fails to wrap. It checks that read-only pattern writes and accesses to the empty window leave memory untouched, which catches a design that writes anyway or fills the buffer with bus garbage.

// File: rtl/vport_pkg.sv
package vport_pkg;
  localparam int VADDR_W  = 14;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 13;
  localparam int TABLE_W  = 10;
  localparam int PAL_W    = 5;
  localparam int WIDE_STEP = 32;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  typedef enum logic [1:0] {
    AREA_PAT  = 2'd0,
    AREA_NAME = 2'd1,
    AREA_PAL  = 2'd2,
    AREA_NONE = 2'd3
  } area_e;

  typedef struct packed {
    logic loadHigh;
    logic loadLow;
    logic stepAddr;
    logic issueRead;
    logic issueWrite;
    logic fillBuf;
  } strobe_t;
endpackage

// File: rtl/vport_fold.sv
module vport_fold
  import vport_pkg::*;
#(
  parameter int ADDR_W = VADDR_W,
  parameter int IDXW   = IDX_W,
  parameter int TBLW   = TABLE_W,
  parameter int PALW   = PAL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mirrorVert,
  output area_e             area,
  output logic [IDXW-1:0]   index
);
  localparam int TOP_W     = 2;
  localparam int PAGE_W    = 4;
  localparam logic [PALW-1:0] BACKDROP_ALIAS = PALW'(1) << (PALW - 1);

  logic [TOP_W-1:0]  quarter;
  logic [PAGE_W-1:0] page;
  logic              physTable;
  logic [PALW-1:0]   palIdx;

  assign quarter = addr[ADDR_W-1 -: TOP_W];
  assign page    = addr[ADDR_W-TOP_W-1 -: PAGE_W];

  always_comb begin
    physTable = mirrorVert ? addr[TBLW] : addr[TBLW+1];
    palIdx    = addr[PALW-1:0];
    if (palIdx == BACKDROP_ALIAS) palIdx = '0;
  end

  always_comb begin
    area  = AREA_NONE;
    index = '0;
    unique case (quarter)
      2'b00, 2'b01: begin
        area  = AREA_PAT;
        index = addr[IDXW-1:0];
      end
      2'b10: begin
        area  = AREA_NAME;
        index = IDXW'({physTable, addr[TBLW-1:0]});
      end
      default: begin
        if (&page) begin
          area  = AREA_PAL;
          index = IDXW'(palIdx);
        end
      end
    endcase
  end
endmodule

// File: rtl/vport_ctrl.sv
module vport_ctrl
  import vport_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrite,
  input  logic       regRead,
  input  logic [1:0] regSel,
  output strobe_t    strb
);
  logic wantLow;
  logic rdStage1;
  logic rdStage2;
  logic addrWr;
  logic dataWr;
  logic dataRd;
  logic statRd;

  assign addrWr = regWrite && (regSel == SEL_ADDR);
  assign dataWr = regWrite && (regSel == SEL_DATA);
  assign dataRd = regRead  && (regSel == SEL_DATA);
  assign statRd = regRead  && (regSel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wantLow  <= 1'b0;
      rdStage1 <= 1'b0;
      rdStage2 <= 1'b0;
    end else begin
      if (statRd)      wantLow <= 1'b0;
      else if (addrWr) wantLow <= ~wantLow;
      rdStage1 <= dataRd;
      rdStage2 <= rdStage1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.loadHigh   = addrWr && !wantLow;
    strb.loadLow    = addrWr && wantLow;
    strb.issueWrite = dataWr;
    strb.issueRead  = dataRd;
    strb.stepAddr   = dataWr || dataRd;
    strb.fillBuf    = rdStage2;
  end
endmodule

// File: rtl/vport_dpath.sv
module vport_dpath
  import vport_pkg::*;
#(
  parameter int ADDR_W = VADDR_W,
  parameter int DW     = DATA_W,
  parameter int IDXW   = IDX_W,
  parameter int STEP_W = WIDE_STEP
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [DW-1:0]   wrData,
  input  logic            incBy32,
  input  logic            mirrorVert,
  input  logic            patternRo,
  input  logic [DW-1:0]   memRdata,
  output logic [DW-1:0]   rdData,
  output logic            memReq,
  output logic            memWe,
  output logic [1:0]      memArea,
  output logic [IDXW-1:0] memIndex,
  output logic [DW-1:0]   memWdata
);
  localparam int HI_W = ADDR_W - DW;

  logic [ADDR_W-1:0] curAddr;
  logic [HI_W-1:0]   hiTemp;
  logic [DW-1:0]     readBuf;
  logic [ADDR_W-1:0] stepVal;
  area_e             curArea;
  logic [IDXW-1:0]   curIndex;
  area_e             areaQ;
  logic              accessOk;
  logic              writeOk;
  logic              noneQ1;
  logic              noneQ2;

  vport_fold #(.ADDR_W(ADDR_W), .IDXW(IDXW)) folder (
    .addr      (curAddr),
    .mirrorVert(mirrorVert),
    .area      (curArea),
    .index     (curIndex)
  );

  assign stepVal  = incBy32 ? ADDR_W'(STEP_W) : ADDR_W'(1);
  assign accessOk = (curArea != AREA_NONE);
  assign writeOk  = accessOk && !((curArea == AREA_PAT) && patternRo);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      hiTemp   <= '0;
      readBuf  <= '0;
      memReq   <= 1'b0;
      memWe    <= 1'b0;
      areaQ    <= AREA_PAT;
      memIndex <= '0;
      memWdata <= '0;
      noneQ1   <= 1'b0;
      noneQ2   <= 1'b0;
    end else begin
      if (strb.loadHigh) hiTemp <= wrData[HI_W-1:0];

      if (strb.loadLow)       curAddr <= {hiTemp, wrData};
      else if (strb.stepAddr) curAddr <= curAddr + stepVal;

      memReq <= 1'b0;
      memWe  <= 1'b0;
      if (strb.issueWrite) begin
        memReq   <= writeOk;
        memWe    <= writeOk;
        areaQ    <= curArea;
        memIndex <= curIndex;
        memWdata <= wrData;
      end else if (strb.issueRead) begin
        memReq   <= accessOk;
        areaQ    <= curArea;
        memIndex <= curIndex;
      end

      noneQ1 <= strb.issueRead && !accessOk;
      noneQ2 <= noneQ1;
      if (strb.fillBuf) readBuf <= noneQ2 ? '0 : memRdata;
    end
  end

  assign memArea = areaQ;
  assign rdData  = readBuf;
endmodule

// File: rtl/vram_port.sv
module vram_port
  import vport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              incBy32,
  input  logic              mirrorVert,
  input  logic              patternRo,
  output logic [DATA_W-1:0] rdData,
  output logic              memReq,
  output logic              memWe,
  output logic [1:0]        memArea,
  output logic [IDX_W-1:0]  memIndex,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  strobe_t strb;

  vport_ctrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrite(regWrite),
    .regRead (regRead),
    .regSel  (regSel),
    .strb    (strb)
  );

  vport_dpath dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .incBy32   (incBy32),
    .mirrorVert(mirrorVert),
    .patternRo (patternRo),
    .memRdata  (memRdata),
    .rdData    (rdData),
    .memReq    (memReq),
    .memWe     (memWe),
    .memArea   (memArea),
    .memIndex  (memIndex),
    .memWdata  (memWdata)
  );
endmodule

// File: rtl/vport_chk.sv
module vport_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrite,
  input logic        regRead,
  input logic [1:0]  regSel,
  input logic        patternRo,
  input logic        memReq,
  input logic        memWe,
  input logic [1:0]  memArea,
  input logic [12:0] memIndex
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (!memReq && !memWe));

  // R4
  req_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> $past(regSel == 2'd1 && (regWrite || regRead)));

  // R4
  we_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R9
  ro_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memArea == 2'd0) |-> !$past(patternRo));

  // R10
  no_gap_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memArea != 2'd3));

  // R8
  pal_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memArea == 2'd2) |-> (memIndex < 13'd32 && memIndex != 13'd16));

  // R7
  name_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memArea == 2'd1) |-> (memIndex < 13'd2048));
endmodule

bind vram_port vport_chk chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrite (regWrite),
  .regRead  (regRead),
  .regSel   (regSel),
  .patternRo(patternRo),
  .memReq   (memReq),
  .memWe    (memWe),
  .memArea  (memArea),
  .memIndex (memIndex)
);

// File: tb/vram_port_test.sv
`timescale 1ns/1ps
module vram_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic        regRead = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic        incBy32 = 1'b0;
  logic        mirrorVert = 1'b1;
  logic        patternRo = 1'b0;
  logic [7:0]  rdData;
  logic        memReq;
  logic        memWe;
  logic [1:0]  memArea;
  logic [12:0] memIndex;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = 8'd0;

  int total = 0;
  int bad = 0;
  bit sawReq = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vram_port uut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regSel(regSel), .wrData(wrData), .incBy32(incBy32),
    .mirrorVert(mirrorVert), .patternRo(patternRo), .rdData(rdData),
    .memReq(memReq), .memWe(memWe), .memArea(memArea), .memIndex(memIndex),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // storage behind the memory port, keyed by area and index
  logic [7:0] phys [int];
  always @(posedge clk) begin
    if (memReq) begin
      sawReq = 1;
      if (memWe) phys[memArea * 8192 + memIndex] = memWdata;
      else memRdata <= phys.exists(memArea * 8192 + memIndex) ?
                       phys[memArea * 8192 + memIndex] : 8'd0;
    end
  end

  // behavioural reference model of the logical space
  logic [7:0] store [int];
  int mAddr, mHi, pendCnt, c;
  bit mLow;
  logic [7:0] mBuf, pendVal;

  function automatic int canon(int a);
    int t, k, p;
    if (a < 'h2000) return a;
    if (a < 'h3000) begin
      t = (a - 'h2000) / 1024;
      k = mirrorVert ? (t % 2) : (t / 2) * 2;
      return 'h2000 + k * 1024 + a % 1024;
    end
    if (a < 'h3F00) return -1;
    p = a % 32;
    if (p == 16) p = 0;
    return 'h3F00 + p;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAddr = 0; mHi = 0; mLow = 0; mBuf = 0; pendCnt = 0; pendVal = 0;
    end else begin
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) mBuf = pendVal;
      end
      if (regWrite && regSel == 2'd0) begin
        if (!mLow) begin mHi = wrData % 64; mLow = 1; end
        else begin mAddr = mHi * 256 + wrData; mLow = 0; end
      end
      if (regRead && regSel == 2'd2) mLow = 0;
      if (regWrite && regSel == 2'd1) begin
        c = canon(mAddr);
        if (c >= 0 && !(c < 'h2000 && patternRo)) store[c] = wrData;
        mAddr = (mAddr + (incBy32 ? 32 : 1)) % 16384;
      end
      if (regRead && regSel == 2'd1) begin
        c = canon(mAddr);
        pendVal = (c >= 0 && store.exists(c)) ? store[c] : 8'd0;
        pendCnt = 2;
        mAddr = (mAddr + (incBy32 ? 32 : 1)) % 16384;
      end
    end
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // every-cycle comparison of the buffer against the model
  always @(negedge clk) begin
    if (rstN && !done) check("R6 cycle", rdData, mBuf);
  end

  task automatic regOp(bit isWr, logic [1:0] sel, logic [7:0] d);
    regWrite = isWr; regRead = !isWr; regSel = sel; wrData = d;
    @(negedge clk);
    regWrite = 0; regRead = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setAddr(int a);
    regOp(1, 2'd0, 8'((a >> 8) & 8'hFF));
    regOp(1, 2'd0, 8'(a & 8'hFF));
  endtask

  task automatic dWr(logic [7:0] d);
    regOp(1, 2'd1, d);
  endtask

  task automatic dRd(output logic [7:0] got);
    regRead = 1; regSel = 2'd1;
    #1 got = rdData;
    @(negedge clk);
    regRead = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] g;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 rdData", rdData, 8'h00);
    check("R1 memReq", {7'd0, memReq}, 8'h00);
    // R1: address starts at zero
    dWr(8'hC3);
    setAddr('h0000);
    dRd(g); check("R6 stale", g, 8'h00);
    dRd(g); check("R1 addr0", g, 8'hC3);
    // R4 R6: step by one
    setAddr('h2005);
    dWr(8'hA1); dWr(8'hA2);
    setAddr('h2005);
    dRd(g); check("R6 stale2", g, 8'h00);
    dRd(g); check("R4 first", g, 8'hA1);
    dRd(g); check("R4 second", g, 8'hA2);
    // R4: step by 32
    incBy32 = 1;
    setAddr('h2100);
    dWr(8'h11); dWr(8'h22);
    incBy32 = 0;
    setAddr('h2120);
    dRd(g); dRd(g); check("R4 step32", g, 8'h22);
    incBy32 = 1;
    setAddr('h2100);
    dRd(g); dRd(g); check("R6 rd32 a", g, 8'h11);
    dRd(g); check("R6 rd32 b", g, 8'h22);
    incBy32 = 0;
    // R2: high bits 7:6 dropped
    regOp(1, 2'd0, 8'hE1); regOp(1, 2'd0, 8'h40);
    dWr(8'h5E);
    setAddr('h2140);
    dRd(g); dRd(g); check("R2 hibits", g, 8'h5E);
    // R3: status read restarts sequence
    regOp(1, 2'd0, 8'h22);
    regOp(0, 2'd2, 8'h00);
    setAddr('h2310);
    dWr(8'h4B);
    setAddr('h2310);
    dRd(g); dRd(g); check("R3 toggle", g, 8'h4B);
    // R7: vertical then horizontal mirroring
    setAddr('h2A08); dWr(8'h77);
    setAddr('h2208); dRd(g); dRd(g); check("R7 vert", g, 8'h77);
    mirrorVert = 0;
    setAddr('h2608); dWr(8'h66);
    setAddr('h2208); dRd(g); dRd(g); check("R7 horz", g, 8'h66);
    setAddr('h2E08); dWr(8'h55);
    setAddr('h2A08); dRd(g); dRd(g); check("R7 horz hi", g, 8'h55);
    mirrorVert = 1;
    // R8: palette backdrop sharing and repeat
    setAddr('h3F10); dWr(8'h3C);
    setAddr('h3F00); dRd(g); dRd(g); check("R8 backdrop", g, 8'h3C);
    setAddr('h3F24); dWr(8'h09);
    setAddr('h3F04); dRd(g); dRd(g); check("R8 repeat", g, 8'h09);
    setAddr('h3F30); dRd(g); dRd(g); check("R8 alias30", g, 8'h3C);
    // R9: read-only pattern area
    setAddr('h0100); dWr(8'h5A);
    patternRo = 1;
    setAddr('h0100); dWr(8'hFF);
    setAddr('h0100); dRd(g); dRd(g); check("R9 ro", g, 8'h5A);
    patternRo = 0;
    // R10: empty window
    setAddr('h0100); dRd(g);
    sawReq = 0;
    setAddr('h3000); dWr(8'h99);
    setAddr('h3000);
    dRd(g); check("R10 stale", g, 8'h5A);
    dRd(g); check("R10 zero", g, 8'h00);
    check("R10 noreq", {7'd0, sawReq}, 8'h00);
    // R5: wrap modulo 0x4000
    setAddr('h3FFF); dWr(8'h31); dWr(8'h42);
    setAddr('h0000); dRd(g); dRd(g); check("R5 wrap", g, 8'h42);
    setAddr('h3F1F); dRd(g); dRd(g); check("R5 last", g, 8'h31);
    incBy32 = 1;
    setAddr('h3FF0); dWr(8'h17); dWr(8'h18);
    incBy32 = 0;
    setAddr('h0010); dRd(g); dRd(g); check("R5 wrap32", g, 8'h18);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule